// File: doc/BRIEF.md
# Halfword Left-to-Left Transfer Unit

This unit executes the left-to-left halfword transfer instructions of a 36-bit accumulator machine. Each word is two 18-bit halves: the left half in bits 35:18 and the right half in bits 17:0. The operation always copies a source left half into the destination's left half. The variant decides the destination's right half: a plain copy keeps it, zero-fill clears it and ones-fill sets it to all ones. The mode decides the source and the destination. Basic mode moves memory into an accumulator. Immediate mode takes the word 0,,E with no memory access. Memory mode moves an accumulator into memory. Self mode rewrites a memory word in place and copies it into the accumulator.

A controller supplies a one-cycle `start` with the 9-bit opcode, the 4-bit accumulator number, the effective address and the current PC. The unit owns a 16-entry accumulator file and reports every write to it on a dedicated write port. It reaches memory through a request/acknowledge port that has a fault return. When it finishes, it pulses either a done with a next-PC strobe, a read fault, or an illegal-opcode report.

Top module: `hw_xfer_unit`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `ac_we`, `fault_valid` and `illegal` are all low.
- R2: Basic ones-fill (octal 520): the unit reads memory at the EA and writes {mem.left, 777777} to accumulator AC.
- R3: Basic zero-fill (octal 510): the accumulator receives {mem.left, 0}.
- R4: Basic plain (octal 500): the accumulator receives {mem.left, old AC.right}.
- R5: Immediate mode (octal 521 / 511 / 501) makes no memory request. It writes {0, 777777}, all zeros, or {0, old AC.right} respectively.
- R6: Memory mode with zero/ones fill (octal 512 / 522) writes {AC.left, fill} to the EA with no read and no accumulator write.
- R7: Self mode (octal 5x3) reads the EA, writes the filled word back to the EA, and writes it to the accumulator only when AC is nonzero.
- R8: When a read returns `mem_fault`, the unit pulses `fault_valid` with `fault_addr` equal to the EA and `fault_rd` high. It makes no accumulator write, no memory write and no done.
- R9: An opcode outside octal 500-503, 510-513, 520-523 pulses `illegal` with `illegal_pc` = {pc_section, pc_offset}, which equals section<<18 | offset. It makes no accumulator write and no memory request.
- R10: Each completed instruction pulses `done` and `npc_valid` for exactly one cycle, with `npc_offset` = pc_offset+1 modulo 2^18.
- R11: A memory request holds its address and direction until acknowledged. `busy` is high from the cycle after `start` until the outcome cycle, and `start` is ignored while busy.
- R12: Memory mode plain (octal 502) reads the EA, then writes {AC.left, mem.right} back to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| opcode | input | 9 | Instruction opcode |
| ac_num | input | 4 | Accumulator number |
| ea | input | ADDR_W | Effective address |
| pc_section | input | SEC_W | PC section |
| pc_offset | input | 18 | PC offset |
| busy | output | 1 | Instruction in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | Request accepted |
| mem_rdata | input | 36 | Read data, valid with ack |
| mem_fault | input | 1 | Read failed, valid with ack |
| ac_we | output | 1 | Accumulator write strobe |
| ac_widx | output | 4 | Accumulator written |
| ac_wdata | output | 36 | Accumulator write value |
| done | output | 1 | Instruction completed |
| npc_valid | output | 1 | Next-PC strobe |
| npc_offset | output | 18 | Incremented PC offset |
| fault_valid | output | 1 | Read fault abort |
| fault_addr | output | ADDR_W | Faulting address |
| fault_rd | output | 1 | Fault was on a read |
| illegal | output | 1 | Unrecognised opcode |
| illegal_pc | output | SEC_W+18 | PC of the illegal instruction |

## Verification
The checker watches, on every cycle, the shape of the handshakes and pulses. It confirms that done is a single cycle with its next-PC strobe, that a pending request holds address and direction, that the idle unit makes no request, and that fault and illegal outcomes come with no accumulator write. The data results cannot be seen from the handshakes alone. These are the filled word chosen for each variant and mode, the suppressed accumulator write in self mode with AC zero, the preserved right halves of the plain variant, and the wrap of the next-PC offset. Only the directed scenarios show them, by comparing memory and accumulator traffic against values worked out by hand.

// File: rtl/hw_xfer_pkg.sv
package hw_xfer_pkg;
  localparam int HALF_W = 18;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [1:0] {FILL_KEEP = 2'd0, FILL_ZERO = 2'd1, FILL_ONES = 2'd2} fill_e;
  typedef enum logic [1:0] {MD_BASIC = 2'd0, MD_IMM = 2'd1, MD_MEM = 2'd2, MD_SELF = 2'd3} mode_e;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_RD = 3'd1, ST_WR = 3'd2, ST_FIN = 3'd3, ST_FLT = 3'd4, ST_ERR = 3'd5
  } state_e;
endpackage

// File: rtl/hw_xfer_decode.sv
module hw_xfer_decode
  import hw_xfer_pkg::*;
(
  input  logic [8:0] opcode,
  output logic       op_ok,
  output fill_e      fill,
  output mode_e      mode
);
  logic grp_ok;
  always_comb begin
    grp_ok = (opcode[5:3] == 3'o0) || (opcode[5:3] == 3'o1) || (opcode[5:3] == 3'o2);
    op_ok  = (opcode[8:6] == 3'o5) && !opcode[2] && grp_ok;
    fill   = fill_e'(opcode[4:3]);
    mode   = mode_e'(opcode[1:0]);
  end
endmodule

// File: rtl/hw_xfer_merge.sv
module hw_xfer_merge
  import hw_xfer_pkg::*;
(
  input  fill_e              fill,
  input  logic [HALF_W-1:0]  left_src,
  input  logic [HALF_W-1:0]  right_keep,
  output logic [WORD_W-1:0]  word
);
  logic [HALF_W-1:0] right;
  always_comb begin
    case (fill)
      FILL_ZERO: right = '0;
      FILL_ONES: right = '1;
      default:   right = right_keep;
    endcase
    word = {left_src, right};
  end
endmodule

// File: rtl/hw_xfer_acfile.sv
module hw_xfer_acfile
  import hw_xfer_pkg::*;
#(
  parameter int NUM_AC = 16,
  localparam int IDX_W = $clog2(NUM_AC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] regs_q [NUM_AC];

  for (genvar i = 0; i < NUM_AC; i++) begin : g_ac
    logic en;
    assign en = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[i] <= '0;
      else if (en) regs_q[i] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/hw_xfer_unit.sv
module hw_xfer_unit
  import hw_xfer_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SEC_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [8:0]               opcode,
  input  logic [3:0]               ac_num,
  input  logic [ADDR_W-1:0]        ea,
  input  logic [SEC_W-1:0]         pc_section,
  input  logic [17:0]              pc_offset,
  output logic                     busy,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [35:0]              mem_wdata,
  input  logic                     mem_ack,
  input  logic [35:0]              mem_rdata,
  input  logic                     mem_fault,
  output logic                     ac_we,
  output logic [3:0]               ac_widx,
  output logic [35:0]              ac_wdata,
  output logic                     done,
  output logic                     npc_valid,
  output logic [17:0]              npc_offset,
  output logic                     fault_valid,
  output logic [ADDR_W-1:0]        fault_addr,
  output logic                     fault_rd,
  output logic                     illegal,
  output logic [SEC_W+17:0]        illegal_pc
);
  localparam int NUM_AC = 16;

  state_e state_q, state_d;
  fill_e  fill_q, dec_fill;
  mode_e  mode_q, dec_mode;
  logic   dec_ok;
  logic [3:0]        acn_q;
  logic [ADDR_W-1:0] ea_q;
  logic [SEC_W-1:0]  sec_q;
  logic [HALF_W-1:0] off_q;
  logic [WORD_W-1:0] mdat_q;
  logic [WORD_W-1:0] ac_rd, result;
  logic [HALF_W-1:0] left_src, right_keep;
  logic              ld_en, md_en;

  hw_xfer_decode u_dec (.opcode(opcode), .op_ok(dec_ok), .fill(dec_fill), .mode(dec_mode));

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:
        if (start) begin
          if (!dec_ok)                                    state_d = ST_ERR;
          else if (dec_mode == MD_IMM)                    state_d = ST_FIN;
          else if (dec_mode == MD_MEM && dec_fill != FILL_KEEP) state_d = ST_WR;
          else                                            state_d = ST_RD;
        end
      ST_RD:
        if (mem_ack) begin
          if (mem_fault)                 state_d = ST_FLT;
          else if (mode_q == MD_BASIC)   state_d = ST_FIN;
          else                           state_d = ST_WR;
        end
      ST_WR:   if (mem_ack) state_d = ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ld_en = (state_q == ST_IDLE) && start;
  assign md_en = (state_q == ST_RD) && mem_ack && !mem_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= FILL_KEEP;
      mode_q <= MD_BASIC;
      acn_q  <= '0;
      ea_q   <= '0;
      sec_q  <= '0;
      off_q  <= '0;
    end else if (ld_en) begin
      fill_q <= dec_fill;
      mode_q <= dec_mode;
      acn_q  <= ac_num;
      ea_q   <= ea;
      sec_q  <= pc_section;
      off_q  <= pc_offset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mdat_q <= '0;
    else if (md_en) mdat_q <= mem_rdata;
  end

  hw_xfer_acfile #(.NUM_AC(NUM_AC)) u_acs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ac_we), .wr_idx(ac_widx), .wr_data(ac_wdata),
    .rd_idx(acn_q), .rd_data(ac_rd)
  );

  // source and kept halves by mode
  always_comb begin
    case (mode_q)
      MD_MEM:  left_src = ac_rd[WORD_W-1:HALF_W];
      MD_IMM:  left_src = '0;
      default: left_src = mdat_q[WORD_W-1:HALF_W];
    endcase
    if (mode_q == MD_BASIC || mode_q == MD_IMM) right_keep = ac_rd[HALF_W-1:0];
    else                                        right_keep = mdat_q[HALF_W-1:0];
  end

  hw_xfer_merge u_mrg (.fill(fill_q), .left_src(left_src), .right_keep(right_keep), .word(result));

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = ea_q;
  assign mem_wdata = result;

  assign ac_we    = (state_q == ST_FIN) &&
                    ((mode_q == MD_BASIC) || (mode_q == MD_IMM) ||
                     ((mode_q == MD_SELF) && (acn_q != 4'd0)));
  assign ac_widx  = acn_q;
  assign ac_wdata = result;

  assign done        = (state_q == ST_FIN);
  assign npc_valid   = (state_q == ST_FIN);
  assign npc_offset  = off_q + 18'd1;
  assign fault_valid = (state_q == ST_FLT);
  assign fault_addr  = ea_q;
  assign fault_rd    = (state_q == ST_FLT);
  assign illegal     = (state_q == ST_ERR);
  assign illegal_pc  = {sec_q, off_q};
endmodule

// File: rtl/hw_xfer_chk.sv
module hw_xfer_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              ac_we,
  input logic              done,
  input logic              npc_valid,
  input logic              fault_valid,
  input logic              illegal
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_npc_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> npc_valid);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !ac_we && !done));
  p_fault_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (!ac_we && !done && !mem_req));
  p_illegal_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!ac_we && !mem_req && !done));
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault_valid, illegal}));
endmodule

bind hw_xfer_unit hw_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .ac_we(ac_we), .done(done),
  .npc_valid(npc_valid), .fault_valid(fault_valid), .illegal(illegal)
);

// File: tb/hw_xfer_unit_tb.sv
module hw_xfer_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int SEC_W  = 12;
  localparam logic [17:0] ONES = 18'o777777;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [8:0] opcode = '0;
  logic [3:0] ac_num = '0;
  logic [ADDR_W-1:0] ea = '0;
  logic [SEC_W-1:0] pc_section = '0;
  logic [17:0] pc_offset = '0;
  logic busy, mem_req, mem_we, ac_we, done, npc_valid, fault_valid, fault_rd, illegal;
  logic [ADDR_W-1:0] mem_addr, fault_addr;
  logic [35:0] mem_wdata, ac_wdata;
  logic [3:0] ac_widx;
  logic [17:0] npc_offset;
  logic [SEC_W+17:0] illegal_pc;
  logic mem_ack = 1'b0, mem_fault = 1'b0;
  logic [35:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_xfer_unit #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_dut (.*);

  int n_run = 0, n_fail = 0;
  logic [35:0] mem [16];
  logic fault_en = 1'b0;
  logic [3:0] fault_at = '0;

  int req_cnt, wr_cnt, acw_cnt, done_cnt, flt_cnt, ill_cnt;
  logic [35:0] last_ac;
  logic [3:0]  last_acidx;
  logic [17:0] last_npc;
  logic [ADDR_W-1:0] last_faddr;
  logic last_frd;
  logic [SEC_W+17:0] last_ipc;

  // memory model and output monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_fault <= 1'b0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        req_cnt++;
        if (fault_en && mem_addr[3:0] == fault_at) mem_fault <= 1'b1;
        else begin
          mem_fault <= 1'b0;
          if (mem_we) begin mem[mem_addr[3:0]] = mem_wdata; wr_cnt++; end
          else mem_rdata <= mem[mem_addr[3:0]];
        end
      end else begin
        mem_ack <= 1'b0; mem_fault <= 1'b0;
      end
      if (ac_we) begin acw_cnt++; last_ac = ac_wdata; last_acidx = ac_widx; end
      if (done && npc_valid) begin done_cnt++; last_npc = npc_offset; end
      if (fault_valid) begin flt_cnt++; last_faddr = fault_addr; last_frd = fault_rd; end
      if (illegal) begin ill_cnt++; last_ipc = illegal_pc; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    req_cnt = 0; wr_cnt = 0; acw_cnt = 0; done_cnt = 0; flt_cnt = 0; ill_cnt = 0;
    last_ac = '0; last_acidx = '0; last_npc = '0; last_faddr = '0; last_frd = 1'b0; last_ipc = '0;
  endtask

  task automatic issue(input logic [8:0] op, input logic [3:0] acn, input logic [3:0] addr,
                       input logic [SEC_W-1:0] sec, input logic [17:0] off, input bit poke_busy);
    bit ended;
    clear_obs();
    @(negedge clk);
    opcode = op; ac_num = acn; ea = ADDR_W'(addr); pc_section = sec; pc_offset = off;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      opcode = 9'o777; start = 1'b1;   // unit is busy: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    ended = 1'b0;
    for (int i = 0; i < 40 && !ended; i++) begin
      @(negedge clk);
      if (done_cnt + flt_cnt + ill_cnt > 0) ended = 1'b1;
    end
    if (!ended) chk(1'b0, "watchdog-instr", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [35:0] w(input logic [17:0] l, input logic [17:0] r);
    return {l, r};
  endfunction

  task automatic t_reset();
    chk(!busy && !done && !mem_req && !ac_we && !fault_valid && !illegal, "R1 idle outputs",
        {busy, done, mem_req, ac_we, fault_valid, illegal}, 0);
  endtask

  task automatic t_basic_ones();
    mem[2] = w(18'd1, 18'd0);
    issue(9'o520, 4'd1, 4'd2, '0, 18'o100, 1'b1);
    chk(last_ac == w(18'd1, ONES), "R2 AC value", last_ac, w(18'd1, ONES));
    chk(acw_cnt == 1 && last_acidx == 4'd1, "R2 AC index", last_acidx, 1);
    chk(ill_cnt == 0 && done_cnt == 1, "R11 start ignored while busy", ill_cnt, 0);
    chk(last_npc == 18'o101, "R10 next pc", last_npc, 18'o101);
  endtask

  task automatic t_basic_zero();
    mem[10] = w(18'd6, 18'd6);
    issue(9'o510, 4'd4, 4'd10, '0, 18'd0, 1'b0);
    chk(last_ac == w(18'd6, 18'd0) && last_acidx == 4'd4, "R3 zero fill", last_ac, w(18'd6, 0));
  endtask

  task automatic t_basic_plain();
    mem[9] = w(18'd2, 18'd0);
    issue(9'o500, 4'd1, 4'd9, '0, 18'd0, 1'b0);   // AC1 was 1,,777777
    chk(last_ac == w(18'd2, ONES), "R4 plain keeps right", last_ac, w(18'd2, ONES));
  endtask

  task automatic t_imm();
    issue(9'o521, 4'd5, 4'd3, '0, 18'd0, 1'b0);
    chk(last_ac == w(18'd0, ONES) && req_cnt == 0, "R5 imm ones", last_ac, w(0, ONES));
    issue(9'o511, 4'd5, 4'd3, '0, 18'd0, 1'b0);
    chk(last_ac == 36'd0 && req_cnt == 0 && acw_cnt == 1, "R5 imm zero", last_ac, 0);
    issue(9'o501, 4'd1, 4'd3, '0, 18'd0, 1'b0);    // AC1 = 2,,777777
    chk(last_ac == w(18'd0, ONES) && req_cnt == 0, "R5 imm plain", last_ac, w(0, ONES));
  endtask

  task automatic t_mem_mode();
    mem[3] = w(18'd3, 18'd0);
    issue(9'o520, 4'd2, 4'd3, '0, 18'd0, 1'b0);    // AC2 = 3,,777777
    mem[5] = w(18'd7, 18'd7);
    issue(9'o512, 4'd2, 4'd5, '0, 18'd0, 1'b0);
    chk(mem[5] == w(18'd3, 18'd0), "R6 mem written", mem[5], w(3, 0));
    chk(acw_cnt == 0 && req_cnt == 1, "R6 no AC write, no read", {acw_cnt, req_cnt}, 1);
    mem[6] = w(18'd7, 18'o123);
    issue(9'o502, 4'd2, 4'd6, '0, 18'd0, 1'b0);
    chk(mem[6] == w(18'd3, 18'o123) && req_cnt == 2, "R12 plain rmw", mem[6], w(3, 18'o123));
    chk(acw_cnt == 0, "R12 AC untouched", acw_cnt, 0);
  endtask

  task automatic t_self();
    mem[7] = w(18'd4, 18'd1);
    issue(9'o523, 4'd3, 4'd7, '0, 18'd0, 1'b0);
    chk(mem[7] == w(18'd4, ONES), "R7 self mem", mem[7], w(4, ONES));
    chk(acw_cnt == 1 && last_ac == w(18'd4, ONES) && last_acidx == 4'd3, "R7 self AC", last_ac, w(4, ONES));
    mem[8] = w(18'd5, 18'd0);
    issue(9'o513, 4'd0, 4'd8, '0, 18'd0, 1'b0);
    chk(mem[8] == w(18'd5, 18'd0) && wr_cnt == 1, "R7 self AC0 mem", mem[8], w(5, 0));
    chk(acw_cnt == 0, "R7 AC0 not written", acw_cnt, 0);
  endtask

  task automatic t_fault();
    mem[12] = w(18'd9, 18'd9);
    fault_en = 1'b1; fault_at = 4'd12;
    issue(9'o523, 4'd6, 4'd12, '0, 18'd0, 1'b0);
    fault_en = 1'b0;
    chk(flt_cnt == 1 && last_faddr == ADDR_W'(12) && last_frd, "R8 fault report", last_faddr, 12);
    chk(acw_cnt == 0 && wr_cnt == 0 && done_cnt == 0, "R8 no state change", {acw_cnt, wr_cnt, done_cnt}, 0);
    chk(mem[12] == w(18'd9, 18'd9), "R8 memory intact", mem[12], w(9, 9));
  endtask

  task automatic t_illegal();
    issue(9'o504, 4'd1, 4'd2, 12'o17, 18'o1234, 1'b0);
    chk(ill_cnt == 1 && last_ipc == {12'o17, 18'o1234}, "R9 illegal pc", last_ipc, {12'o17, 18'o1234});
    chk(acw_cnt == 0 && req_cnt == 0 && done_cnt == 0, "R9 no effects", {acw_cnt, req_cnt}, 0);
    issue(9'o530, 4'd1, 4'd2, 12'd1, 18'd0, 1'b0);
    chk(ill_cnt == 1 && last_ipc == {12'd1, 18'd0}, "R9 group 53 illegal", last_ipc, {12'd1, 18'd0});
  endtask

  task automatic t_npc_wrap();
    issue(9'o521, 4'd9, 4'd0, '0, ONES, 1'b0);
    chk(done_cnt == 1 && last_npc == 18'd0, "R10 offset wrap", last_npc, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    clear_obs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_ones();
    t_basic_zero();
    t_basic_plain();
    t_imm();
    t_mem_mode();
    t_self();
    t_fault();
    t_illegal();
    t_npc_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule